// File: doc/BRIEF.md
# Fast Interrupt Entry and Return Sequencer

This block sits next to a small CPU core and provides one dedicated low-latency interrupt path. Each of several interrupt sources presents a request, an enable and a 3-bit priority level. When fast mode is switched on in the configuration register, exactly one enabled source programmed at the top level (7) is pulled out of the normal interrupt flow. Its request starts a fixed-length entry sequence. The sequence copies the CPU flag word and program counter into two shadow registers and then loads the program counter from a dedicated vector register.

While the fast handler runs, a return strobe starts a fixed-length return sequence. That sequence reloads the program counter and the flag word from the shadow copies, bit for bit. Every source that is not routed to the fast path is passed through unchanged on a per-source normal request output, for the ordinary interrupt controller. If more than one enabled source is programmed at level 7 while fast mode is on, the block flags a configuration error and does not use the fast path. The block also drives a disable line for the second-generation DMA engine while fast mode is on.

Top module: `fastirq_seq`

## Requirements
- R1: Fast mode is on when bit 3 of the configuration register (register address 0) is 1. A source counts as top priority when its enable is 1 and its level field `src_lvl[3i+2:3i]` equals 3'd7. When fast mode is on, exactly one such source exists, it is requesting and the block is idle, the request is accepted at that clock edge and `busy` goes high in the following cycle.
- R2: At the accepting edge t, `cpu_pc` and `cpu_flg` are stored in shadow registers. `pc_load` is high for one cycle, between edges t+4 and t+5 (the fifth cycle of the sequence), with `pc_tgt` equal to the vector register. No flag load happens on entry.
- R3: `fast_ack` is a one-hot pulse that marks the accepted source. It is high only in the first cycle of the entry sequence, between edges t and t+1.
- R4: After entry, a `fret` strobe sampled at edge r starts the return. `pc_load` and `flg_load` are both high for one cycle, between edges r+2 and r+3, with `pc_tgt` and `flg_tgt` bit-exact copies of the values stored at entry. At edge r+3 the block is idle and `busy` falls.
- R5: `cfg_err` is high while fast mode is on and two or more enabled sources are at level 7. In that case no fast entry is taken, and those sources appear on `norm_req`.
- R6: `norm_req[i]` equals `src_req[i] & src_en[i]`, combinationally, for every source that is not the single fast source. This covers levels 0 to 6, and level 7 while fast mode is off.
- R7: `busy` stays high from the first entry cycle through the last return cycle. A fast request present during that window is neither accepted nor shown on `norm_req`. It stays pending and is accepted once the block is idle again.
- R8: `dma2_dis` equals configuration bit 3.
- R9: Both registers reset to zero. A write with `wr_en` high stores `wr_data[7:0]` in the configuration register at address 0, or `wr_data` in the vector register at address 1, from the next cycle on. Writes to addresses 2 and 3 change nothing.
- R10: `fret` has no effect unless the fast handler is running, whether the block is idle or still entering. `pc_tgt` and `flg_tgt` read zero whenever their load strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register address: 0 configuration, 1 vector |
| wr_data | input | PC_W | Register write data |
| src_req | input | N_SRC | Per-source interrupt request |
| src_en | input | N_SRC | Per-source enable |
| src_lvl | input | 3*N_SRC | Per-source priority level, 3 bits each |
| cpu_pc | input | PC_W | Current program counter of the core |
| cpu_flg | input | FLG_W | Current flag word of the core |
| fret | input | 1 | Fast-return strobe from the handler |
| norm_req | output | N_SRC | Requests passed on to the normal controller |
| cfg_err | output | 1 | More than one fast candidate while fast mode is on |
| dma2_dis | output | 1 | Disable for the second-generation DMA engine |
| busy | output | 1 | Fast entry, handler or return in progress |
| fast_ack | output | N_SRC | One-hot acknowledge of the accepted source |
| pc_load | output | 1 | Program counter load strobe |
| pc_tgt | output | PC_W | Program counter load value |
| flg_load | output | 1 | Flag word load strobe |
| flg_tgt | output | FLG_W | Flag word load value |

## Verification
The main function is exercised in several ways: a single fast request released on acknowledge; a fast request held high through the whole handler, which separates correct pending behaviour from early re-entry or loss of the request; and return strobes sent while idle and in the middle of entry, which must be ignored. The program counter and flag values are changed while the handler runs, so a restore taken from live inputs instead of the shadow copies is caught. A second level-7 source, fast mode switched off and writes to unused addresses show whether the error flag, the normal pass-through and the register decode are kept separate from the fast path.

// File: rtl/fastirq_pkg.sv
package fastirq_pkg;

   localparam int          LVL_W   = 3;
   localparam logic [2:0]  LVL_TOP = 3'd7;
   localparam int          RADDR_W = 2;
   localparam logic [1:0]  RA_CFG  = 2'd0;
   localparam logic [1:0]  RA_VEC  = 2'd1;

   typedef enum logic [1:0] {
      FQ_IDLE    = 2'd0,
      FQ_ENTER   = 2'd1,
      FQ_ROUTINE = 2'd2,
      FQ_RETURN  = 2'd3
   } fq_state_e;

endpackage

// File: rtl/fastirq_regs.sv
module fastirq_regs
   import fastirq_pkg::*;
#(
   parameter int PC_W      = 24,
   parameter int CFG_W     = 8,
   parameter int FAST_BIT  = 3,
   parameter int VEC_ALIGN = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [RADDR_W-1:0] wr_addr,
   input  logic [PC_W-1:0]    wr_data,
   output logic [CFG_W-1:0]   cfg_q,
   output logic [PC_W-1:0]    vec_q,
   output logic               fast_on
);

   logic cfg_we;
   logic vec_we;

   assign cfg_we  = wr_en && (wr_addr == RA_CFG);
   assign vec_we  = wr_en && (wr_addr == RA_VEC);
   assign fast_on = cfg_q[FAST_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (cfg_we) begin
         cfg_q <= wr_data[CFG_W-1:0];
      end
   end

   generate
      if (VEC_ALIGN == 0) begin : g_vec_full
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vec_q <= '0;
            end else if (vec_we) begin
               vec_q <= wr_data;
            end
         end
      end else begin : g_vec_aligned
         logic [PC_W-1:VEC_ALIGN] vec_hi;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vec_hi <= '0;
            end else if (vec_we) begin
               vec_hi <= wr_data[PC_W-1:VEC_ALIGN];
            end
         end
         assign vec_q = {vec_hi, {VEC_ALIGN{1'b0}}};
      end
   endgenerate

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/fastirq_route.sv
module fastirq_route
   import fastirq_pkg::*;
#(
   parameter int N_SRC = 8
) (
   input  logic [N_SRC-1:0]       src_req,
   input  logic [N_SRC-1:0]       src_en,
   input  logic [LVL_W*N_SRC-1:0] src_lvl,
   input  logic                   fast_on,
   output logic [N_SRC-1:0]       norm_req,
   output logic [N_SRC-1:0]       fast_sel,
   output logic                   fast_hit,
   output logic                   cfg_err
);

   localparam int CNT_W = $clog2(N_SRC + 1);

   logic [N_SRC-1:0] is_top;
   logic [CNT_W-1:0] n_top;
   logic             unique_top;

   genvar gi;
   generate
      for (gi = 0; gi < N_SRC; gi++) begin : g_src
         assign is_top[gi] = src_en[gi] && (src_lvl[LVL_W*gi +: LVL_W] == LVL_TOP);
      end
   endgenerate

   always_comb begin
      n_top = '0;
      for (int i = 0; i < N_SRC; i++) begin
         n_top = n_top + CNT_W'(is_top[i]);
      end
   end

   assign unique_top = fast_on && (n_top == CNT_W'(1));
   assign cfg_err    = fast_on && (n_top > CNT_W'(1));
   assign fast_sel   = unique_top ? is_top : '0;
   assign fast_hit   = |(fast_sel & src_req);
   assign norm_req   = src_req & src_en & ~fast_sel;

endmodule

// File: rtl/fastirq_fsm.sv
module fastirq_fsm
   import fastirq_pkg::*;
#(
   parameter int N_SRC   = 8,
   parameter int PC_W    = 24,
   parameter int FLG_W   = 16,
   parameter int ENT_CYC = 5,
   parameter int RET_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fast_hit,
   input  logic [N_SRC-1:0] fast_sel,
   input  logic             fret,
   input  logic [PC_W-1:0]  cpu_pc,
   input  logic [FLG_W-1:0] cpu_flg,
   input  logic [PC_W-1:0]  vec_q,
   output logic             busy,
   output logic [N_SRC-1:0] fast_ack,
   output logic             pc_load,
   output logic [PC_W-1:0]  pc_tgt,
   output logic             flg_load,
   output logic [FLG_W-1:0] flg_tgt
);

   localparam int MAX_CYC = (ENT_CYC > RET_CYC) ? ENT_CYC : RET_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] ENT_LAST = CNT_W'(ENT_CYC - 1);
   localparam logic [CNT_W-1:0] RET_LAST = CNT_W'(RET_CYC - 1);
   localparam int LEN_W   = CNT_W + 1;

   fq_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [PC_W-1:0]  save_pc;
   logic [FLG_W-1:0] save_flg;
   logic [N_SRC-1:0] ack_src;
   logic             accept;
   logic             ent_last;
   logic             ret_last;

   assign accept   = (state == FQ_IDLE) && fast_hit;
   assign ent_last = (state == FQ_ENTER)  && (cnt == ENT_LAST);
   assign ret_last = (state == FQ_RETURN) && (cnt == RET_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= FQ_IDLE;
         cnt      <= '0;
         save_pc  <= '0;
         save_flg <= '0;
         ack_src  <= '0;
      end else begin
         case (state)
            FQ_IDLE: begin
               if (accept) begin
                  state    <= FQ_ENTER;
                  cnt      <= '0;
                  save_pc  <= cpu_pc;
                  save_flg <= cpu_flg;
                  ack_src  <= fast_sel;
               end
            end
            FQ_ENTER: begin
               if (ent_last) begin
                  state <= FQ_ROUTINE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            FQ_ROUTINE: begin
               if (fret) begin
                  state <= FQ_RETURN;
                  cnt   <= '0;
               end
            end
            FQ_RETURN: begin
               if (ret_last) begin
                  state <= FQ_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= FQ_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   always_comb begin
      busy     = (state != FQ_IDLE);
      fast_ack = ((state == FQ_ENTER) && (cnt == '0)) ? ack_src : '0;
      pc_load  = ent_last || ret_last;
      flg_load = ret_last;
      pc_tgt   = '0;
      flg_tgt  = '0;
      if (ent_last) begin
         pc_tgt = vec_q;
      end else if (ret_last) begin
         pc_tgt  = save_pc;
         flg_tgt = save_flg;
      end
   end

   // assertion aid: cycles since busy rose, saturating
   logic [LEN_W-1:0] busy_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_len <= '0;
      end else if (!busy) begin
         busy_len <= '0;
      end else if (busy_len != {LEN_W{1'b1}}) begin
         busy_len <= busy_len + 1'b1;
      end
   end

   AST_ENTRY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_load && !flg_load) |-> (busy_len == LEN_W'(ENT_CYC - 1))); // R2
   AST_SAVE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && fast_hit) |=> (save_pc == $past(cpu_pc)) && (save_flg == $past(cpu_flg))); // R2
   AST_ACK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($countones(fast_ack) == 1)); // R3
   AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fast_ack)); // R3
   AST_RET_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      flg_load |-> pc_load); // R4
   AST_RET_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      flg_load |=> !busy); // R4
   AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (fast_ack == '0)); // R7

endmodule

// File: rtl/fastirq_seq.sv
module fastirq_seq
   import fastirq_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int PC_W      = 24,
   parameter int FLG_W     = 16,
   parameter int CFG_W     = 8,
   parameter int FAST_BIT  = 3,
   parameter int ENT_CYC   = 5,
   parameter int RET_CYC   = 3,
   parameter int VEC_ALIGN = 0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [1:0]             wr_addr,
   input  logic [PC_W-1:0]        wr_data,
   input  logic [N_SRC-1:0]       src_req,
   input  logic [N_SRC-1:0]       src_en,
   input  logic [3*N_SRC-1:0]     src_lvl,
   input  logic [PC_W-1:0]        cpu_pc,
   input  logic [FLG_W-1:0]       cpu_flg,
   input  logic                   fret,
   output logic [N_SRC-1:0]       norm_req,
   output logic                   cfg_err,
   output logic                   dma2_dis,
   output logic                   busy,
   output logic [N_SRC-1:0]       fast_ack,
   output logic                   pc_load,
   output logic [PC_W-1:0]        pc_tgt,
   output logic                   flg_load,
   output logic [FLG_W-1:0]       flg_tgt
);

   generate
      if (N_SRC < 2)              begin : g_bad_nsrc  $error("N_SRC must be at least 2");            end
      if (CFG_W > PC_W)           begin : g_bad_cfgw  $error("CFG_W must not exceed PC_W");          end
      if (FAST_BIT >= CFG_W)      begin : g_bad_bit   $error("FAST_BIT must lie inside CFG_W");      end
      if (ENT_CYC < 1)            begin : g_bad_ent   $error("ENT_CYC must be at least 1");          end
      if (RET_CYC < 1)            begin : g_bad_ret   $error("RET_CYC must be at least 1");          end
      if (VEC_ALIGN >= PC_W)      begin : g_bad_align $error("VEC_ALIGN must be below PC_W");        end
   endgenerate

   logic [CFG_W-1:0] cfg_q;
   logic [PC_W-1:0]  vec_q;
   logic             fast_on;
   logic [N_SRC-1:0] fast_sel;
   logic             fast_hit;

   fastirq_regs #(
      .PC_W      (PC_W),
      .CFG_W     (CFG_W),
      .FAST_BIT  (FAST_BIT),
      .VEC_ALIGN (VEC_ALIGN)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .cfg_q   (cfg_q),
      .vec_q   (vec_q),
      .fast_on (fast_on)
   );

   fastirq_route #(
      .N_SRC (N_SRC)
   ) u_route (
      .src_req  (src_req),
      .src_en   (src_en),
      .src_lvl  (src_lvl),
      .fast_on  (fast_on),
      .norm_req (norm_req),
      .fast_sel (fast_sel),
      .fast_hit (fast_hit),
      .cfg_err  (cfg_err)
   );

   fastirq_fsm #(
      .N_SRC   (N_SRC),
      .PC_W    (PC_W),
      .FLG_W   (FLG_W),
      .ENT_CYC (ENT_CYC),
      .RET_CYC (RET_CYC)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_hit (fast_hit),
      .fast_sel (fast_sel),
      .fret     (fret),
      .cpu_pc   (cpu_pc),
      .cpu_flg  (cpu_flg),
      .vec_q    (vec_q),
      .busy     (busy),
      .fast_ack (fast_ack),
      .pc_load  (pc_load),
      .pc_tgt   (pc_tgt),
      .flg_load (flg_load),
      .flg_tgt  (flg_tgt)
   );

   assign dma2_dis = fast_on;

   AST_ERR_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_err && !busy) |=> !busy); // R5
   AST_PENDING_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !cfg_err) |-> ((norm_req & fast_sel) == '0)); // R7

   logic unused_cfg;
   assign unused_cfg = ^cfg_q;

endmodule

// File: tb/fastirq_seq_bench.sv
`timescale 1ns/1ps
module fastirq_seq_bench;

   localparam int N   = 8;
   localparam int PW  = 24;
   localparam int FW  = 16;
   localparam int ENT = 5;
   localparam int RET = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [PW-1:0] wr_data = '0;
   logic [N-1:0]  src_req = '0;
   logic [N-1:0]  src_en = '0;
   logic [3*N-1:0] src_lvl = '0;
   logic [PW-1:0] cpu_pc = '0;
   logic [FW-1:0] cpu_flg = '0;
   logic          fret = 1'b0;
   logic [N-1:0]  norm_req;
   logic          cfg_err;
   logic          dma2_dis;
   logic          busy;
   logic [N-1:0]  fast_ack;
   logic          pc_load;
   logic [PW-1:0] pc_tgt;
   logic          flg_load;
   logic [FW-1:0] flg_tgt;

   always #2.5 clk = ~clk;

   fastirq_seq u_fastirq_seq (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .src_req(src_req), .src_en(src_en), .src_lvl(src_lvl), .cpu_pc(cpu_pc),
      .cpu_flg(cpu_flg), .fret(fret), .norm_req(norm_req), .cfg_err(cfg_err),
      .dma2_dis(dma2_dis), .busy(busy), .fast_ack(fast_ack), .pc_load(pc_load),
      .pc_tgt(pc_tgt), .flg_load(flg_load), .flg_tgt(flg_tgt)
   );

   // reference model: 0 idle, 1 entering, 2 handler, 3 returning
   int          m_phase = 0;
   int          m_cnt = 0;
   int          m_src = 0;
   logic [7:0]  m_cfg = '0;
   logic [PW-1:0] m_vec = '0;
   logic [PW-1:0] m_spc = '0;
   logic [FW-1:0] m_sfl = '0;
   int          vectors = 0;
   int          miscompares = 0;
   int          cycles = 0;
   bit          started = 0;
   bit          finished = 0;

   function automatic int count_top();
      int n = 0;
      for (int i = 0; i < N; i++)
         if (src_en[i] && src_lvl[3*i +: 3] == 3'd7) n++;
      return n;
   endfunction

   function automatic int top_index();
      for (int i = 0; i < N; i++)
         if (src_en[i] && src_lvl[3*i +: 3] == 3'd7) return i;
      return 0;
   endfunction

   always @(posedge clk) begin
      bit acc;
      cycles++;
      started = 1;
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_cfg = '0; m_vec = '0; m_spc = '0; m_sfl = '0; m_src = 0;
      end else begin
         acc = (m_phase == 0) && m_cfg[3] && (count_top() == 1) && src_req[top_index()];
         case (m_phase)
            0: if (acc) begin
                  m_phase = 1; m_cnt = 0; m_spc = cpu_pc; m_sfl = cpu_flg; m_src = top_index();
               end
            1: if (m_cnt == ENT-1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
            2: if (fret) begin m_phase = 3; m_cnt = 0; end
            default: if (m_cnt == RET-1) begin m_phase = 0; m_cnt = 0; end else m_cnt++;
         endcase
         if (wr_en && wr_addr == 2'd0) m_cfg = wr_data[7:0];
         if (wr_en && wr_addr == 2'd1) m_vec = wr_data;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         logic [N-1:0] e_norm, e_ack;
         logic e_pcl, e_fll;
         logic [PW-1:0] e_pct;
         logic [FW-1:0] e_flt;
         bit fon, uniq;
         int nt;
         fon  = m_cfg[3];
         nt   = count_top();
         uniq = fon && nt == 1;
         for (int i = 0; i < N; i++)
            e_norm[i] = src_req[i] && src_en[i] &&
                        !(uniq && src_lvl[3*i +: 3] == 3'd7);
         e_ack = (m_phase == 1 && m_cnt == 0) ? (N'(1) << m_src) : '0;
         e_pcl = (m_phase == 1 && m_cnt == ENT-1) || (m_phase == 3 && m_cnt == RET-1);
         e_fll = (m_phase == 3 && m_cnt == RET-1);
         e_pct = (m_phase == 1 && m_cnt == ENT-1) ? m_vec : (e_fll ? m_spc : '0);
         e_flt = e_fll ? m_sfl : '0;
         check("R6 norm_req", 32'(norm_req), 32'(e_norm));
         check("R5 cfg_err", 32'(cfg_err), 32'(fon && nt > 1));
         check("R8 dma2_dis", 32'(dma2_dis), 32'(fon));
         check("R1/R7 busy", 32'(busy), 32'(m_phase != 0));
         check("R3 fast_ack", 32'(fast_ack), 32'(e_ack));
         check(m_phase == 3 ? "R4 pc_load" : (m_phase == 1 ? "R2 pc_load" : "R10 pc_load"),
               32'(pc_load), 32'(e_pcl));
         check(m_phase == 3 ? "R4 pc_tgt" : "R2/R9/R10 pc_tgt", 32'(pc_tgt), 32'(e_pct));
         check("R4 flg_load", 32'(flg_load), 32'(e_fll));
         check("R4 flg_tgt", 32'(flg_tgt), 32'(e_flt));
      end
   end

   always @(posedge clk) begin
      if (cycles > 20000 && !finished) begin
         finished = 1;
         miscompares++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [1:0] a, logic [PW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick(1);
      wr_en = 1'b0;
   endtask

   task automatic pulse_fret();
      fret = 1'b1; tick(1); fret = 1'b0;
   endtask

   // raise a request and drop it once the block acknowledges it
   task automatic fire(int i);
      src_req[i] = 1'b1;
      for (int k = 0; k < 40; k++) begin
         tick(1);
         if (fast_ack[i]) break;
      end
      src_req[i] = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < N; i++) src_lvl[3*i +: 3] = 3'(i);
      tick(3);                          // reset state (R9)
      rst_n = 1'b1;
      src_en = '1;
      tick(1);
      src_req = '1; tick(2); src_req = '0; tick(1);     // R6: fast mode off
      wr(2'd1, 24'h3A5C70);
      wr(2'd0, 24'h000008);                             // R1, R8
      cpu_pc = 24'h001234; cpu_flg = 16'hA5C3;
      pulse_fret(); tick(2);                            // R10: idle
      src_req[3] = 1'b1; tick(2); src_req[3] = 1'b0;    // R6 with fast on
      src_req[7] = 1'b1; tick(2);                       // R2/R3: entry
      pulse_fret();                                     // R10: during entry
      src_req[7] = 1'b0;
      tick(5);
      cpu_pc = 24'hFFFFFF; cpu_flg = 16'h0000;          // R4: live values differ
      tick(3); pulse_fret(); tick(6);
      cpu_pc = 24'h00ABCD; cpu_flg = 16'h5A5A;
      src_req[7] = 1'b1; tick(9);                       // R7: held through handler
      cpu_pc = 24'h111111; pulse_fret(); tick(12);
      pulse_fret(); tick(3);
      src_req[7] = 1'b0; tick(8); pulse_fret(); tick(6);
      src_lvl[3*2 +: 3] = 3'd7;                         // R5: two candidates
      src_req = 8'h84; tick(4); src_req = '0;
      src_lvl[3*2 +: 3] = 3'd2; tick(1);
      src_en[7] = 1'b0; src_req[7] = 1'b1; tick(3);     // disabled source
      src_req[7] = 1'b0; src_en[7] = 1'b1;
      wr(2'd2, 24'hFFFFFF); wr(2'd3, 24'h000000);       // R9: unused addresses
      wr(2'd0, 24'h0000F7);                             // fast off, other bits set
      src_req[7] = 1'b1; tick(3); src_req[7] = 1'b0;
      wr(2'd0, 24'h000008);
      cpu_pc = 24'h800001; cpu_flg = 16'hFFFF;
      fire(7); tick(1);
      wr(2'd1, 24'h0F0F0F);                             // vector change during entry
      tick(8); pulse_fret(); tick(6);
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule